// File: doc/BRIEF.md
# Truncating Integer Divider with Overflow Detection

This block divides a dividend by a divisor one quotient bit per clock, using a restoring shift-subtract loop. A single control set picks between signed and unsigned operation and between a full-width (doubleword, 64-bit) form and a half-width (word, 32-bit) form. The word forms first widen the low half of each operand to full width: signed forms sign-extend and unsigned forms zero-extend. The result is the quotient only, rounded toward zero. Signed operands are handled by dividing their magnitudes and negating the quotient when the two operand signs differ.

Some operand pairs have no defined quotient. These are a zero divisor and, for signed forms, the most negative value divided by minus one. Such pairs are caught in the cycle that accepts the request. They finish at once, with a zeroed quotient and a zeroed condition field, and raise the overflow flag when overflow reporting is enabled. A sticky summary flag collects every raised overflow until reset.

When the record input is set, the block also produces a three-bit sign classification of the result (negative, positive, zero). Callers pulse `start` while the block is idle, then wait for the one-cycle `done` pulse. The results stay on the outputs until the next completion.

Top module: `trunc_div`

## Requirements
- R1: Signed doubleword division gives the quotient rounded toward zero, so the implied remainder has the sign of the dividend (for example -7/2 = -3 and 7/-2 = -3).
- R2: Unsigned division gives floor(dividend / divisor) of the operands read as unsigned values.
- R3: With `op_word` set, only bits [31:0] of each operand are used, sign-extended (signed) or zero-extended (unsigned) to 64 bits. `quot` is the full 64-bit quotient of the extended operands, so bits [63:32] are the extension of bits [31:0] for signed forms and zero for unsigned forms.
- R4: A zero divisor (after extension) is an overflow case. For signed forms, so is dividend 0x8000_0000_0000_0000 with divisor all ones in doubleword form, or dividend bits [31:0] = 0x8000_0000 with divisor bits [31:0] = 0xFFFF_FFFF in word form. An overflow case completes with `quot` = 0, `cond` = 3'b000 and `ovf` = `ovf_en`.
- R5: A completion that is not an overflow case leaves `ovf` at 0, whatever `ovf_en` is.
- R6: `sum_ovf` becomes 1 at any completion where `ovf` is 1. It stays 1 until reset, through later completions.
- R7: With `rec_en` set, `cond` bit 2 = result negative, bit 1 = result positive and bit 0 = result zero. The test is a signed comparison with zero of `quot[31:0]` in word form and of `quot[63:0]` in doubleword form, for signed and unsigned forms alike. With `rec_en` clear, `cond` = 3'b000.
- R8: `done` is a one-cycle pulse. Counting the edge that samples `start` as edge 1, `done` is high after edge 1 for an overflow case, after edge 33 for a word form and after edge 65 for a doubleword form.
- R9: `busy` is high while the quotient is being iterated, and `start` is ignored while `busy` is high. Operands presented then do not affect the result or the timing of the operation in progress.
- R10: After reset, `busy`, `done`, `quot`, `ovf`, `sum_ovf` and `cond` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; sampled only while idle |
| op_signed | input | 1 | 1 = signed operands, 0 = unsigned |
| op_word | input | 1 | 1 = word form using operand bits [31:0] |
| ovf_en | input | 1 | Enables reporting of overflow cases on `ovf` |
| rec_en | input | 1 | Enables the condition field |
| dividend | input | 64 | Dividend operand |
| divisor | input | 64 | Divisor operand |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| quot | output | 64 | Quotient, held until the next completion |
| ovf | output | 1 | Overflow flag of the last completion |
| sum_ovf | output | 1 | Sticky overflow summary |
| cond | output | 3 | {negative, positive, zero} of the result |

## Verification
Every cycle, the assertions check these properties:
- the overflow summary is sticky and covers the overflow flag;
- an overflow completion shows a zero quotient and a clear condition field;
- the condition field never has more than one bit set, and has exactly one set on a recorded normal completion;
- the captured divisor cannot change while the loop runs.

The quotient values themselves can only be shown by the bench's scenarios. The bench compares them with its own arithmetic on signed and unsigned operands, both sizes, sign combinations, extension of the word halves, and the two overflow patterns. The same is true of the exact completion latency and of the way a `start` raised mid-operation is ignored.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // positions inside the three-bit condition field
    localparam int CND_NEG  = 2;
    localparam int CND_POS  = 1;
    localparam int CND_ZERO = 0;

endpackage

// File: rtl/tdiv_prep.sv
module tdiv_prep #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          sgn,
    input  logic          wrd,
    output logic [DW-1:0] mag_a,
    output logic [DW-1:0] mag_b,
    output logic          neg_res,
    output logic          ovf_case
);
    localparam int HW = DW / 2;

    logic [DW-1:0] ext_a;
    logic [DW-1:0] ext_b;
    logic          a_neg;
    logic          b_neg;
    logic          a_min;
    logic          b_m1;

    // widen the half-width operands according to signedness
    always_comb begin
        if (wrd) begin
            ext_a = sgn ? {{HW{op_a[HW-1]}}, op_a[HW-1:0]} : {{HW{1'b0}}, op_a[HW-1:0]};
            ext_b = sgn ? {{HW{op_b[HW-1]}}, op_b[HW-1:0]} : {{HW{1'b0}}, op_b[HW-1:0]};
        end else begin
            ext_a = op_a;
            ext_b = op_b;
        end
    end

    assign a_neg   = sgn & ext_a[DW-1];
    assign b_neg   = sgn & ext_b[DW-1];
    assign mag_a   = a_neg ? (~ext_a + 1'b1) : ext_a;
    assign mag_b   = b_neg ? (~ext_b + 1'b1) : ext_b;
    assign neg_res = a_neg ^ b_neg;

    // most negative value over minus one, judged at the active size
    assign a_min = wrd ? (op_a[HW-1:0] == {1'b1, {(HW-1){1'b0}}})
                       : (op_a == {1'b1, {(DW-1){1'b0}}});
    assign b_m1  = wrd ? (op_b[HW-1:0] == {HW{1'b1}}) : (op_b == {DW{1'b1}});

    assign ovf_case = (ext_b == '0) | (sgn & a_min & b_m1);

endmodule

// File: rtl/tdiv_step.sv
module tdiv_step #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] rem_i,
    input  logic [DW-1:0] q_i,
    input  logic [DW-1:0] dsr,
    output logic [DW-1:0] rem_o,
    output logic [DW-1:0] q_o
);
    logic [DW:0]   shifted;
    logic [DW-1:0] diff;
    logic          fits;

    assign shifted = {rem_i, q_i[DW-1]};
    assign fits    = shifted >= {1'b0, dsr};
    // when fits is set the true difference is below dsr, so DW bits suffice
    assign diff    = shifted[DW-1:0] - dsr;
    assign rem_o   = fits ? diff : shifted[DW-1:0];
    assign q_o     = {q_i[DW-2:0], fits};

endmodule

// File: rtl/tdiv_post.sv
module tdiv_post
    import tdiv_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] mag_q,
    input  logic          neg,
    input  logic          wrd,
    input  logic          rec,
    output logic [DW-1:0] quot,
    output logic [2:0]    cond
);
    localparam int HW = DW / 2;

    logic sign_bit;
    logic is_zero;

    assign quot     = neg ? (~mag_q + 1'b1) : mag_q;
    assign sign_bit = wrd ? quot[HW-1] : quot[DW-1];
    assign is_zero  = wrd ? (quot[HW-1:0] == '0) : (quot == '0);

    always_comb begin
        cond = 3'b000;
        if (rec) begin
            cond[CND_NEG]  = sign_bit;
            cond[CND_ZERO] = is_zero;
            cond[CND_POS]  = !sign_bit && !is_zero;
        end
    end

endmodule

// File: rtl/trunc_div.sv
module trunc_div
    import tdiv_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_signed,
    input  logic          op_word,
    input  logic          ovf_en,
    input  logic          rec_en,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] quot,
    output logic          ovf,
    output logic          sum_ovf,
    output logic [2:0]    cond
);
    localparam int HW = DW / 2;
    localparam int CW = $clog2(DW);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rem;
        logic [DW-1:0] q;
        logic [DW-1:0] dsr;
        logic          neg;
        logic          wrd;
        logic          rec;
        logic          done;
        logic [DW-1:0] quot;
        logic [2:0]    cond;
        logic          ovf;
        logic          sum_ovf;
    } st_t;

    st_t st_d;
    st_t st_q;

    logic [DW-1:0] mag_a;
    logic [DW-1:0] mag_b;
    logic          neg_res;
    logic          ovf_case;
    logic [DW-1:0] step_rem;
    logic [DW-1:0] step_q;
    logic [DW-1:0] fin_quot;
    logic [2:0]    fin_cond;

    tdiv_prep #(.DW(DW)) u_prep (
        .op_a     (dividend),
        .op_b     (divisor),
        .sgn      (op_signed),
        .wrd      (op_word),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .neg_res  (neg_res),
        .ovf_case (ovf_case)
    );

    tdiv_step #(.DW(DW)) u_step (
        .rem_i (st_q.rem),
        .q_i   (st_q.q),
        .dsr   (st_q.dsr),
        .rem_o (step_rem),
        .q_o   (step_q)
    );

    tdiv_post #(.DW(DW)) u_post (
        .mag_q (step_q),
        .neg   (st_q.neg),
        .wrd   (st_q.wrd),
        .rec   (st_q.rec),
        .quot  (fin_quot),
        .cond  (fin_cond)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (start) begin
                if (ovf_case) begin
                    st_d.done    = 1'b1;
                    st_d.quot    = '0;
                    st_d.cond    = 3'b000;
                    st_d.ovf     = ovf_en;
                    st_d.sum_ovf = st_q.sum_ovf | ovf_en;
                end else begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = op_word ? CW'(HW - 1) : CW'(DW - 1);
                    st_d.rem   = '0;
                    st_d.q     = op_word ? {mag_a[HW-1:0], {HW{1'b0}}} : mag_a;
                    st_d.dsr   = mag_b;
                    st_d.neg   = neg_res;
                    st_d.wrd   = op_word;
                    st_d.rec   = rec_en;
                end
            end
        end else begin
            st_d.rem = step_rem;
            st_d.q   = step_q;
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == '0) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                st_d.quot  = fin_quot;
                st_d.cond  = fin_cond;
                st_d.ovf   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.phase == PH_RUN);
    assign done    = st_q.done;
    assign quot    = st_q.quot;
    assign ovf     = st_q.ovf;
    assign sum_ovf = st_q.sum_ovf;
    assign cond    = st_q.cond;

    // R6
    sum_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_ovf |=> sum_ovf);

    // R6
    ovf_in_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> sum_ovf);

    // R4
    ovf_zero_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (quot == '0 && cond == 3'b000));

    // R7
    cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cond));

    // R7
    cond_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.rec && st_q.cnt == '0) |=> ($countones(cond) == 1));

    // R9
    dsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.dsr));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/trunc_div_bench.sv
module trunc_div_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_signed = 1'b0;
    logic        op_word = 1'b0;
    logic        ovf_en = 1'b0;
    logic        rec_en = 1'b0;
    logic [63:0] dividend = '0;
    logic [63:0] divisor = '0;
    logic        busy;
    logic        done;
    logic [63:0] quot;
    logic        ovf;
    logic        sum_ovf;
    logic [2:0]  cond;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_sum = 1'b0;

    always #5 clk = ~clk;

    trunc_div u_trunc_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_signed (op_signed),
        .op_word   (op_word),
        .ovf_en    (ovf_en),
        .rec_en    (rec_en),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quot      (quot),
        .ovf       (ovf),
        .sum_ovf   (sum_ovf),
        .cond      (cond)
    );

    function automatic logic [63:0] widen(input logic [63:0] v, input logic sg, input logic wd);
        if (!wd) return v;
        return sg ? {{32{v[31]}}, v[31:0]} : {32'h0, v[31:0]};
    endfunction

    function automatic logic bad_pair(input logic [63:0] a, input logic [63:0] b,
                                      input logic sg, input logic wd);
        logic zero_b;
        logic min_m1;
        zero_b = (widen(b, sg, wd) == 64'h0);
        if (wd) min_m1 = (a[31:0] == 32'h8000_0000) && (b[31:0] == 32'hFFFF_FFFF);
        else    min_m1 = (a == 64'h8000_0000_0000_0000) && (b == 64'hFFFF_FFFF_FFFF_FFFF);
        return zero_b || (sg && min_m1);
    endfunction

    function automatic logic [63:0] ref_quot(input logic [63:0] a, input logic [63:0] b,
                                             input logic sg, input logic wd);
        logic [63:0] ea;
        logic [63:0] eb;
        logic signed [63:0] sq;
        ea = widen(a, sg, wd);
        eb = widen(b, sg, wd);
        if (sg) begin
            sq = $signed(ea) / $signed(eb);
            return sq;
        end
        return ea / eb;
    endfunction

    function automatic logic [2:0] ref_cond(input logic [63:0] q, input logic wd, input logic rc);
        logic n;
        logic z;
        if (!rc) return 3'b000;
        n = wd ? q[31] : q[63];
        z = wd ? (q[31:0] == 32'h0) : (q == 64'h0);
        return {n, !n && !z, z};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic sg,
                          input logic wd, input logic oe, input logic rc);
        logic        bp;
        logic [63:0] eq_v;
        int          lat;
        int          exp_lat;
        string       qreq;
        bp = bad_pair(a, b, sg, wd);
        eq_v = bp ? 64'h0 : ref_quot(a, b, sg, wd);
        exp_lat = bp ? 1 : (wd ? 33 : 65);
        qreq = bp ? "R4" : (wd ? "R3" : (sg ? "R1" : "R2"));
        @(negedge clk);
        dividend = a; divisor = b; op_signed = sg; op_word = wd;
        ovf_en = oe; rec_en = rc; start = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        // R9: iteration in progress after a normal start
        check("R9", "busy after start", {63'h0, busy}, {63'h0, !bp});
        while (!done && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        check("R8", "latency", 64'(lat), 64'(exp_lat));
        check(qreq, "quotient", quot, eq_v);
        if (bp) check("R4", "ovf on bad pair", {63'h0, ovf}, {63'h0, oe});
        else    check("R5", "ovf on normal", {63'h0, ovf}, 64'h0);
        check(bp ? "R4" : "R7", "cond", {61'h0, cond}, {61'h0, ref_cond(eq_v, wd, rc && !bp)});
        exp_sum = exp_sum | (bp && oe);
        check("R6", "sum_ovf", {63'h0, sum_ovf}, {63'h0, exp_sum});
        @(posedge clk);
        @(negedge clk);
        check("R8", "done one cycle", {63'h0, done}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog: actual=hung expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20511));
        repeat (3) @(negedge clk);
        // R10: reset values
        check("R10", "busy reset", {63'h0, busy}, 64'h0);
        check("R10", "done reset", {63'h0, done}, 64'h0);
        check("R10", "quot reset", quot, 64'h0);
        check("R10", "flags reset", {60'h0, ovf, sum_ovf, cond}, 64'h0);
        rst_n = 1'b1;

        // R1: sign combinations, truncation toward zero
        run_op(64'd7, 64'd2, 1'b1, 1'b0, 1'b1, 1'b1);
        run_op(-64'sd7, 64'd2, 1'b1, 1'b0, 1'b1, 1'b1);
        run_op(64'd7, -64'sd2, 1'b1, 1'b0, 1'b0, 1'b1);
        run_op(-64'sd7, -64'sd2, 1'b1, 1'b0, 1'b1, 1'b0);
        // R4 with reporting off: no flag, R6 summary stays clear
        run_op(64'd9, 64'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        // R2 and R7: unsigned results compared as signed
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 1'b0, 1'b0, 1'b1, 1'b1);
        run_op(64'h8000_0000_0000_0000, 64'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        run_op(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b1);
        run_op(64'd0, 64'd5, 1'b1, 1'b0, 1'b0, 1'b1);
        // R3: word extension
        run_op(64'h1234_5678_FFFF_FFF9, 64'hAAAA_0000_0000_0002, 1'b1, 1'b1, 1'b1, 1'b1);
        run_op(64'hABCD_0000_FFFF_FFFF, 64'h7777_0000_0000_0001, 1'b0, 1'b1, 1'b1, 1'b1);
        run_op(64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1);
        // R4: both bad patterns, both sizes
        run_op(64'h0000_0001_8000_0000, 64'h0000_0005_FFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1);
        run_op(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1);
        run_op(64'h55, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, 1'b1, 1'b0);
        // R6: sticky across a clean completion
        run_op(64'd100, 64'd10, 1'b0, 1'b0, 1'b1, 1'b1);

        // R9: start while busy is ignored
        begin
            int lat;
            @(negedge clk);
            dividend = 64'd100; divisor = 64'd7; op_signed = 1'b0; op_word = 1'b0;
            ovf_en = 1'b1; rec_en = 1'b1; start = 1'b1;
            @(posedge clk);
            lat = 1;
            @(negedge clk);
            start = 1'b0;
            repeat (10) begin
                @(posedge clk);
                lat++;
                @(negedge clk);
            end
            dividend = 64'd5; divisor = 64'd0; start = 1'b1;
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
            check("R9", "busy kept after ignored start", {63'h0, busy}, 64'h1);
            while (!done && lat < 200) begin
                @(posedge clk);
                lat++;
                @(negedge clk);
            end
            check("R9", "latency unaffected", 64'(lat), 64'd65);
            check("R9", "result unaffected", quot, 64'd14);
            check("R9", "no ovf from ignored start", {63'h0, ovf}, 64'h0);
        end

        // random mix
        for (int i = 0; i < 250; i++) begin
            logic [63:0] a;
            logic [63:0] b;
            logic        sg;
            logic        wd;
            int          pat;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            sg = 1'($urandom);
            wd = 1'($urandom);
            pat = int'($urandom % 8);
            case (pat)
                0: b = 64'h0;
                1: begin a = wd ? 64'h8000_0000 : 64'h8000_0000_0000_0000; b = '1; end
                2: begin a = 64'($urandom % 5000); b = 64'($urandom % 37) + 1; end
                3: b = 64'(-(int'($urandom % 9) + 1));
                4: b = 64'h1 << ($urandom % 64);
                5: b = b >> ($urandom % 60);
                default: ;
            endcase
            run_op(a, b, sg, wd, 1'($urandom), 1'($urandom));
        end

        summary();
    end

endmodule